// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block is the presentation stage that sits in front of one processor in a two-level interrupt controller. A source stage offers it interrupts, each as a 24-bit source number with an 8-bit priority. Lower priority values are more favoured. The block keeps at most one interrupt pending. A request that loses, or a pending one that is displaced, is handed back to the source stage through a reject pulse so that the source can offer it again later. One interrupt line goes to the processor.

Software talks to the block through one-cycle operations. Accept reads the pending word and takes the interrupt. Poll reads it with no side effect. The other operations write the processor priority, write the inter-processor-interrupt (IPI) request level, and signal end of interrupt. The IPI request competes with the sources and appears under a fixed reserved source number, set by a parameter whose default is 2. A resend pulse asks the source stage to offer again any interrupts that were rejected earlier.

Top module: `irq_presenter`

## Requirements
- R1: `rd_data` is the pending word. Bits 31:24 hold the processor priority and bits 23:0 hold the pending source number, where 0 means nothing is pending. `irq_o` is high exactly when the source field is non-zero.
- R2: After reset, `rd_data` is 0, `rd_ipi` is 0xFF, the internal pending priority is 0xFF, and `irq_o`, `rej_vld`, `resend_o` and `eoi_vld` are low.
- R3: A request with priority p is rejected when p ≥ the processor priority, or when a source is pending with pending priority ≤ p. In that case `rej_src` carries the request's number and the pending word does not change.
- R4: A request that wins replaces the pending source and its priority, and raises `irq_o`. If another source was pending, that old number is rejected.
- R5: Accept (op 1) returns the current `rd_data`. After it, the priority field takes the pending priority, the source field is 0, the pending priority is 0xFF and `irq_o` is low.
- R6: Set priority (op 3, value in `op_data[7:0]`) with a value below the current one clears the pending source when one exists and the new value ≤ the pending priority. The clear lowers `irq_o` and rejects that source.
- R7: Set priority with a value ≥ the current one, while nothing is pending, issues a resend. The resend first runs the IPI check when the IPI level is below the new priority.
- R8: Set IPI (op 4, value in `op_data[7:0]`) stores the level. When the level is below the processor priority, the IPI check runs. The check does nothing if a source is pending with pending priority ≤ the level. Otherwise it rejects any pending source, loads source number 2 with the level as pending priority, and raises `irq_o`.
- R9: End of interrupt (op 5) loads `op_data[31:24]` as the processor priority and forwards `op_data[23:0]` on `eoi_src`. If nothing is pending, it then issues a resend, which includes the IPI check.
- R10: Poll (op 2) changes no state and produces no pulse.
- R11: Source number 2 (the IPI) never appears on a reject or end-of-interrupt pulse.
- R12: `req_rdy` is low whenever `op_code` is non-zero. A request presented in such a cycle is not taken and has no effect. Op 0 is idle.
- R13: Every operation and request takes effect at the next rising edge. `rej_vld`, `resend_o` and `eoi_vld` are single-cycle pulses in the cycle after the cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| req_vld | input | 1 | Source stage offers an interrupt |
| req_src | input | 24 | Offered source number |
| req_prio | input | 8 | Offered priority |
| req_rdy | output | 1 | Offer is taken this cycle |
| op_code | input | 3 | 0 idle, 1 accept, 2 poll, 3 set priority, 4 set IPI, 5 end of interrupt |
| op_data | input | 32 | Operand of the operation |
| rd_data | output | 32 | Pending word (priority and source) |
| rd_ipi | output | 8 | IPI request level |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_vld | output | 1 | Reject pulse to the source stage |
| rej_src | output | 24 | Rejected source number |
| resend_o | output | 1 | Resend pulse to the source stage |
| eoi_vld | output | 1 | End-of-interrupt pulse to the source stage |
| eoi_src | output | 24 | Source number that is finished |

## Verification
Every operation or request driven before a rising edge shows its effect exactly one edge later. That effect covers `rd_data`, `rd_ipi` and `irq_o`, and also the reject, resend and end-of-interrupt pulses. The only exception is `req_rdy`, which responds within the same cycle. The bench drives each stimulus at a falling edge and updates its reference model at once. At the next falling edge it compares every output with the model, so no output is sampled before it is due. The value that accept returns is checked in the cycle of the accept, before the edge that clears it.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_POLL   = 3'd2,
    OP_SETPRI = 3'd3,
    OP_SETIPI = 3'd4,
    OP_EOI    = 3'd5
  } pres_op_e;
endpackage

// File: rtl/irq_pres_next.sv
module irq_pres_next
  import irq_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int DATA_W = SRC_W + PRIO_W
) (
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] op_data,
  input  logic              req_vld,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] cppr_q,
  input  logic [SRC_W-1:0]  xsrc_q,
  input  logic [PRIO_W-1:0] pprio_q,
  input  logic [PRIO_W-1:0] ipi_q,
  input  logic              irq_q,
  output logic              load_en,
  output logic              req_take,
  output logic [PRIO_W-1:0] cppr_d,
  output logic [SRC_W-1:0]  xsrc_d,
  output logic [PRIO_W-1:0] pprio_d,
  output logic [PRIO_W-1:0] ipi_d,
  output logic              irq_d,
  output logic              rej_fire,
  output logic [SRC_W-1:0]  rej_num,
  output logic              rsnd_fire,
  output logic              eoi_fire,
  output logic [SRC_W-1:0]  eoi_num
);
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);

  pres_op_e          op;
  logic              busy;
  logic              chk_en;
  logic [PRIO_W-1:0] wr_pri;
  logic [PRIO_W-1:0] eoi_pri;

  assign op       = pres_op_e'(op_code);
  assign busy     = (op != OP_IDLE);
  assign req_take = req_vld && !busy;
  assign load_en  = busy || req_vld;
  assign wr_pri   = op_data[PRIO_W-1:0];
  assign eoi_pri  = op_data[DATA_W-1 -: PRIO_W];

  always_comb begin
    cppr_d    = cppr_q;
    xsrc_d    = xsrc_q;
    pprio_d   = pprio_q;
    ipi_d     = ipi_q;
    irq_d     = irq_q;
    rej_fire  = 1'b0;
    rej_num   = '0;
    rsnd_fire = 1'b0;
    eoi_fire  = 1'b0;
    eoi_num   = '0;
    chk_en    = 1'b0;
    unique case (op)
      OP_ACCEPT: begin
        cppr_d  = pprio_q;
        xsrc_d  = '0;
        pprio_d = PRIO_MAX;
        irq_d   = 1'b0;
      end
      OP_SETPRI: begin
        cppr_d = wr_pri;
        if (wr_pri < cppr_q) begin
          if ((xsrc_q != '0) && (wr_pri <= pprio_q)) begin
            xsrc_d   = '0;
            pprio_d  = PRIO_MAX;
            irq_d    = 1'b0;
            rej_fire = 1'b1;
            rej_num  = xsrc_q;
          end
        end else if (xsrc_q == '0) begin
          rsnd_fire = 1'b1;
          chk_en    = (ipi_q < wr_pri);
        end
      end
      OP_SETIPI: begin
        ipi_d  = wr_pri;
        chk_en = (wr_pri < cppr_q);
      end
      OP_EOI: begin
        cppr_d   = eoi_pri;
        eoi_fire = 1'b1;
        eoi_num  = op_data[SRC_W-1:0];
        if (xsrc_q == '0) begin
          rsnd_fire = 1'b1;
          chk_en    = (ipi_q < eoi_pri);
        end
      end
      OP_IDLE: begin
        if (req_vld) begin
          if ((req_prio >= cppr_q) || ((xsrc_q != '0) && (pprio_q <= req_prio))) begin
            rej_fire = 1'b1;
            rej_num  = req_src;
          end else begin
            if (xsrc_q != '0) begin
              rej_fire = 1'b1;
              rej_num  = xsrc_q;
            end
            xsrc_d  = req_src;
            pprio_d = req_prio;
            irq_d   = 1'b1;
          end
        end
      end
      default: ;
    endcase
    // IPI check, shared by the IPI write and by resend
    if (chk_en && !((xsrc_q != '0) && (pprio_q <= ipi_d))) begin
      if (xsrc_q != '0) begin
        rej_fire = 1'b1;
        rej_num  = xsrc_q;
      end
      xsrc_d  = IPI_NUM;
      pprio_d = ipi_d;
      irq_d   = 1'b1;
    end
  end
endmodule

// File: rtl/irq_pres_regs.sv
module irq_pres_regs #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PRIO_W-1:0] cppr_d,
  input  logic [SRC_W-1:0]  xsrc_d,
  input  logic [PRIO_W-1:0] pprio_d,
  input  logic [PRIO_W-1:0] ipi_d,
  input  logic              irq_d,
  output logic [PRIO_W-1:0] cppr_q,
  output logic [SRC_W-1:0]  xsrc_q,
  output logic [PRIO_W-1:0] pprio_q,
  output logic [PRIO_W-1:0] ipi_q,
  output logic              irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q  <= '0;
      xsrc_q  <= '0;
      pprio_q <= '1;
      ipi_q   <= '1;
      irq_q   <= 1'b0;
    end else if (load_en) begin
      cppr_q  <= cppr_d;
      xsrc_q  <= xsrc_d;
      pprio_q <= pprio_d;
      ipi_q   <= ipi_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/irq_pres_notify.sv
module irq_pres_notify #(
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rej_fire,
  input  logic [SRC_W-1:0] rej_num,
  input  logic             rsnd_fire,
  input  logic             eoi_fire,
  input  logic [SRC_W-1:0] eoi_num,
  output logic             rej_vld,
  output logic [SRC_W-1:0] rej_src,
  output logic             resend_o,
  output logic             eoi_vld,
  output logic [SRC_W-1:0] eoi_src
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic rej_go;
  logic eoi_go;

  assign rej_go = rej_fire && (rej_num != IPI_NUM);
  assign eoi_go = eoi_fire && (eoi_num != IPI_NUM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_vld  <= 1'b0;
      resend_o <= 1'b0;
      eoi_vld  <= 1'b0;
    end else begin
      rej_vld  <= rej_go;
      resend_o <= rsnd_fire;
      eoi_vld  <= eoi_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_src <= '0;
    end else if (rej_go) begin
      rej_src <= rej_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_src <= '0;
    end else if (eoi_go) begin
      eoi_src <= eoi_num;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int DATA_W = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              req_rdy,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [PRIO_W-1:0] rd_ipi,
  output logic              irq_o,
  output logic              rej_vld,
  output logic [SRC_W-1:0]  rej_src,
  output logic              resend_o,
  output logic              eoi_vld,
  output logic [SRC_W-1:0]  eoi_src
);
  logic              load_en;
  logic [PRIO_W-1:0] cppr_q,  cppr_d;
  logic [SRC_W-1:0]  xsrc_q,  xsrc_d;
  logic [PRIO_W-1:0] pend_prio_q, pprio_d;
  logic [PRIO_W-1:0] ipi_q,   ipi_d;
  logic              irq_q,   irq_d;
  logic              rej_fire, rsnd_fire, eoi_fire;
  logic [SRC_W-1:0]  rej_num, eoi_num;

  irq_pres_next #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_next (
    .op_code  (op_code),
    .op_data  (op_data),
    .req_vld  (req_vld),
    .req_src  (req_src),
    .req_prio (req_prio),
    .cppr_q   (cppr_q),
    .xsrc_q   (xsrc_q),
    .pprio_q  (pend_prio_q),
    .ipi_q    (ipi_q),
    .irq_q    (irq_q),
    .load_en  (load_en),
    .req_take (req_rdy),
    .cppr_d   (cppr_d),
    .xsrc_d   (xsrc_d),
    .pprio_d  (pprio_d),
    .ipi_d    (ipi_d),
    .irq_d    (irq_d),
    .rej_fire (rej_fire),
    .rej_num  (rej_num),
    .rsnd_fire(rsnd_fire),
    .eoi_fire (eoi_fire),
    .eoi_num  (eoi_num)
  );

  irq_pres_regs #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .cppr_d  (cppr_d),
    .xsrc_d  (xsrc_d),
    .pprio_d (pprio_d),
    .ipi_d   (ipi_d),
    .irq_d   (irq_d),
    .cppr_q  (cppr_q),
    .xsrc_q  (xsrc_q),
    .pprio_q (pend_prio_q),
    .ipi_q   (ipi_q),
    .irq_q   (irq_q)
  );

  irq_pres_notify #(.SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_notify (
    .clk      (clk),
    .rst_n    (rst_n),
    .rej_fire (rej_fire),
    .rej_num  (rej_num),
    .rsnd_fire(rsnd_fire),
    .eoi_fire (eoi_fire),
    .eoi_num  (eoi_num),
    .rej_vld  (rej_vld),
    .rej_src  (rej_src),
    .resend_o (resend_o),
    .eoi_vld  (eoi_vld),
    .eoi_src  (eoi_src)
  );

  assign rd_data = {cppr_q, xsrc_q};
  assign rd_ipi  = ipi_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int DATA_W = SRC_W + PRIO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [SRC_W-1:0]  req_src,
  input logic [PRIO_W-1:0] req_prio,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] rd_data,
  input logic [PRIO_W-1:0] rd_ipi,
  input logic              irq_o,
  input logic              rej_vld,
  input logic [SRC_W-1:0]  rej_src,
  input logic [PRIO_W-1:0] pend_prio_q
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  // R1: line follows the source field
  a_r1_line_tracks_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (rd_data[SRC_W-1:0] != '0));

  // R3: a losing request is bounced and leaves the pending word alone
  a_r3_loser_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && op_code == 3'd0 && req_prio >= rd_data[DATA_W-1 -: PRIO_W]
     && req_src != IPI_NUM)
    |=> (rej_vld && rej_src == $past(req_src) && $stable(rd_data)));

  // R5: accept moves pending priority into the priority field
  a_r5_accept_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd1)
    |=> (rd_data[DATA_W-1 -: PRIO_W] == $past(pend_prio_q)
         && rd_data[SRC_W-1:0] == '0 && !irq_o && pend_prio_q == '1));

  // R10: poll is side-effect free
  a_r10_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd2) |=> ($stable(rd_data) && $stable(rd_ipi) && !rej_vld));

  // R11: the IPI number is never handed back
  a_r11_ipi_not_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    rej_vld |-> (rej_src != IPI_NUM));
endmodule

bind irq_presenter irq_presenter_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_src    (req_src),
  .req_prio   (req_prio),
  .op_code    (op_code),
  .rd_data    (rd_data),
  .rd_ipi     (rd_ipi),
  .irq_o      (irq_o),
  .rej_vld    (rej_vld),
  .rej_src    (rej_src),
  .pend_prio_q(pend_prio_q)
);

// File: tb/irq_presenter_tb_top.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
  localparam int IPI = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        req_rdy;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi;
  logic        irq_o, rej_vld, resend_o, eoi_vld;
  logic [23:0] rej_src, eoi_src;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_cppr, m_src, m_pp, m_ipi;
  bit m_irq;
  bit e_rej, e_rsnd, e_eoi;
  int e_rej_src, e_eoi_src;

  always #4 clk = ~clk;

  irq_presenter dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_src(req_src),
    .req_prio(req_prio), .req_rdy(req_rdy), .op_code(op_code),
    .op_data(op_data), .rd_data(rd_data), .rd_ipi(rd_ipi), .irq_o(irq_o),
    .rej_vld(rej_vld), .rej_src(rej_src), .resend_o(resend_o),
    .eoi_vld(eoi_vld), .eoi_src(eoi_src)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R1 rd_data"}, rd_data, (m_cppr << 24) | m_src);
    chk({tag, " R1 irq_o"}, irq_o, m_irq);
    chk({tag, " rd_ipi"}, rd_ipi, m_ipi);
    chk({tag, " R13 rej_vld"}, rej_vld, e_rej);
    if (e_rej) chk({tag, " rej_src"}, rej_src, e_rej_src);
    chk({tag, " R13 resend_o"}, resend_o, e_rsnd);
    chk({tag, " R13 eoi_vld"}, eoi_vld, e_eoi);
    if (e_eoi) chk({tag, " eoi_src"}, eoi_src, e_eoi_src);
  endtask

  task automatic bounce(input int num);
    if (num != IPI) begin
      e_rej = 1'b1;
      e_rej_src = num;
    end
  endtask

  // behavioural model of one cycle
  task automatic model(input int op, input int d, input bit rv, input int rs, input int rp);
    int wp, ep, old_src, old_pp, lvl;
    bit run_chk;
    e_rej = 0; e_rsnd = 0; e_eoi = 0; run_chk = 0;
    old_src = m_src; old_pp = m_pp;
    wp = d & 255;
    ep = (d >> 24) & 255;
    if (op == 1) begin
      m_cppr = m_pp; m_src = 0; m_pp = 255; m_irq = 0;
    end else if (op == 3) begin
      if (wp < m_cppr) begin
        if (m_src != 0 && wp <= m_pp) begin
          bounce(m_src); m_src = 0; m_pp = 255; m_irq = 0;
        end
      end else if (m_src == 0) begin
        e_rsnd = 1; run_chk = (m_ipi < wp);
      end
      m_cppr = wp;
    end else if (op == 4) begin
      m_ipi = wp; run_chk = (wp < m_cppr);
    end else if (op == 5) begin
      m_cppr = ep;
      if ((d & 24'hFFFFFF) != IPI) begin
        e_eoi = 1; e_eoi_src = d & 24'hFFFFFF;
      end
      if (m_src == 0) begin
        e_rsnd = 1; run_chk = (m_ipi < ep);
      end
    end else if (op == 0 && rv) begin
      if (rp >= m_cppr || (m_src != 0 && m_pp <= rp)) bounce(rs);
      else begin
        if (m_src != 0) bounce(m_src);
        m_src = rs; m_pp = rp; m_irq = 1;
      end
    end
    if (run_chk) begin
      lvl = m_ipi;
      if (!(old_src != 0 && old_pp <= lvl)) begin
        if (old_src != 0) bounce(old_src);
        m_src = IPI; m_pp = lvl; m_irq = 1;
      end
    end
  endtask

  task automatic step(input int op, input int d, input bit rv, input int rs,
                      input int rp, input string tag);
    op_code = op[2:0]; op_data = d; req_vld = rv; req_src = rs[23:0]; req_prio = rp[7:0];
    #1;
    chk({tag, " R12 req_rdy"}, req_rdy, (rv && op == 0));
    model(op, d, rv, rs, rp);
    @(negedge clk);
    op_code = 0; req_vld = 0;
    compare_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_cppr = 0; m_src = 0; m_pp = 255; m_ipi = 255; m_irq = 0;
    e_rej = 0; e_rsnd = 0; e_eoi = 0; e_rej_src = 0; e_eoi_src = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R2 reset");

    step(3, 32'hFF, 0, 0, 0, "R7 open priority, resend");
    step(0, 0, 1, 24'h100, 5, "R4 first request wins");
    step(0, 0, 1, 24'h200, 7, "R3 worse than pending");
    step(0, 0, 1, 24'h300, 3, "R4 better displaces old");
    step(2, 0, 0, 0, 0, "R10 poll");
    step(4, 4, 0, 0, 0, "R8 IPI level loses");
    step(4, 1, 0, 0, 0, "R8 IPI level wins");
    step(0, 0, 1, 24'h400, 1, "R3 equal to pending");
    step(1, 0, 0, 0, 0, "R5 accept IPI");
    step(5, 32'hFF000002, 0, 0, 0, "R9 R11 EOI of IPI");
    step(4, 255, 0, 0, 0, "R8 IPI off");
    step(1, 0, 0, 0, 0, "R5 accept");
    step(5, 32'h05000123, 0, 0, 0, "R9 EOI forwarded");
    step(0, 0, 1, 24'h500, 5, "R3 equal to priority");
    step(0, 0, 1, 24'h500, 4, "R4 win");
    step(3, 2, 0, 0, 0, "R6 restrict clears");
    step(0, 0, 1, 24'h600, 1, "R4 win");
    step(3, 1, 0, 0, 0, "R6 restrict equal clears");
    step(3, 3, 0, 0, 0, "R7 relax resend");
    step(2, 0, 1, 24'h700, 0, "R12 request held off");
    step(3, 0, 0, 0, 0, "R6 nothing pending");

    for (int i = 0; i < 400; i++) begin
      int op, d, rp;
      op = $urandom_range(0, 5);
      rp = ($urandom_range(0, 9) == 0) ? 255 : $urandom_range(0, 7);
      d = (op == 5) ? (($urandom_range(0, 8) << 24) | $urandom_range(1, 40))
                    : $urandom_range(0, 8);
      step(op, d, $urandom_range(0, 1), $urandom_range(16, 60), rp, "R13 mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule